// File: doc/BRIEF.md
# Framed Stream CRC Appender

This block sits in a streaming datapath in which every cycle may carry one sample of `DATA_W` bits. Each sample is qualified by a valid strobe, and a frame is marked by a start flag on its first sample and an end flag on its last. The block reproduces each frame at its output after a fixed delay. Straight after the frame's last data sample it inserts the frame's cyclic redundancy checksum as `CRC_LEN / DATA_W` extra samples. The output end flag is moved onto the last checksum sample, so downstream logic and the upstream source can use it as the point where the frame is complete.

The generator polynomial is fixed at elaboration by `CRC_KIND`, and the choice also sets the checksum length. The register is updated `DATA_W` bits per cycle by a parallel next-state function. If a new frame starts while an earlier frame is still being emitted, the earlier frame is cut short and the new checksum starts from zero. When the source leaves exactly the minimum idle gap between frames, the output valid stays high with no holes.

Top module: `crc_append_enc`

## Requirements
- R1: `CRC_KIND` picks the polynomial and length: 0 gives 24 bits with 0x864CFB, 1 gives 24 bits with 0x800063, 2 gives 16 bits with 0x1021, and 3 gives 8 bits with 0x9B. `DATA_W` must divide the length. With the defaults, a frame of the ASCII bytes "123456789" yields the checksum 0x31C3.
- R2: The checksum register starts at all zeros on each accepted start. Bits are fed most significant first, and within a sample bit `DATA_W-1` goes first. No final inversion or reflection is applied.
- R3: Each accepted data sample appears at the output exactly LAT = (CRC_LEN+3)/DATA_W cycles after it was presented. Its data, valid and start come out unchanged, and the end flag of a data sample is never driven.
- R4: After an accepted end sample, the next CRC_LEN/DATA_W output cycles carry the checksum most significant chunk first, each with valid high. The output end is high only on the last chunk.
- R5: An input cycle with valid low is ignored whatever its start, end and data carry. It produces no output sample and leaves the checksum unchanged.
- R6: A valid sample outside a frame (after an end, before a new start) is dropped and produces no output.
- R7: A start that reaches the output stage while an earlier checksum is still being emitted aborts that emission, so that frame gets no output end. A frame that never received an end produces no checksum. The new frame's checksum is computed from zero.
- R8: When frames are separated by exactly CRC_LEN/DATA_W idle input cycles, the output valid stays continuously high across both frames and their checksums.
- R9: While the synchronous active-high reset is asserted and after it is released, the output valid, start and end stay low until a new frame arrives.
- R10: A one-sample frame, with start and end on the same sample, is followed by its full checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | DATA_W | Input sample bits |
| inValid | input | 1 | Input sample qualifier |
| inStart | input | 1 | First sample of a frame |
| inEnd | input | 1 | Last sample of a frame |
| outData | output | DATA_W | Output data or checksum chunk |
| outValid | output | 1 | Output sample qualifier |
| outStart | output | 1 | First output sample of a frame |
| outEnd | output | 1 | Last checksum chunk of a frame |

## Verification
Two of the block's functions can fall in the same output cycle: emitting the tail of one frame's checksum, and letting the delayed start of the next frame through. The bench provokes this by starting a frame three idle cycles after the previous end, which is shorter than the checksum length. It also starts a frame directly after one that never ended. The expected output timeline is built from the requirements. The checksum chunks already shown must match, the remaining chunks must be dropped, no end must appear for the cut frame, and the new frame's checksum must be computed from zero. A second pairing is the last checksum chunk followed in the very next cycle by new data at minimum spacing, which is judged by requiring an unbroken output valid.

// File: rtl/crc_append_pkg.sv
package crc_append_pkg;

  // Control bits carried along the delay line.
  typedef struct packed {
    logic v;
    logic s;
    logic e;
  } ctrlBits_t;

  // Strobes from control to datapath, aligned to the output stage.
  typedef struct packed {
    logic dataStep;    // accepted data sample at output stage
    logic frameFirst;  // that sample opens a frame
    logic captureSum;  // that sample closes a frame
    logic shiftSum;    // a checksum chunk is shown this cycle
  } crcStrobe_t;

  function automatic int crcLenOf(input int kind);
    case (kind)
      0, 1:    return 24;
      2:       return 16;
      default: return 8;
    endcase
  endfunction

  function automatic logic [23:0] crcPolyOf(input int kind);
    case (kind)
      0:       return 24'h864CFB;
      1:       return 24'h800063;
      2:       return 24'h001021;
      default: return 24'h00009B;
    endcase
  endfunction

endpackage

// File: rtl/crc_append_ctrl.sv
module crc_append_ctrl
  import crc_append_pkg::*;
#(
  parameter int LAT = 9,
  parameter int NCH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       inStart,
  input  logic       inEnd,
  output crcStrobe_t strb,
  output logic       outValid,
  output logic       outStart,
  output logic       outEnd
);

  localparam int CW = $clog2(NCH + 1);

  // Control delay line, one register per stage.
  for (genvar i = 0; i < LAT; i++) begin : g_stage
    ctrlBits_t q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= '{v: inValid, s: inStart, e: inEnd};
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= g_stage[i-1].q;
      end
    end
  end

  ctrlBits_t tap;
  assign tap = g_stage[LAT-1].q;

  logic          inFrame;
  logic [CW-1:0] sumLeft;
  logic          take;
  logic          showSum;

  assign take    = tap.v && (tap.s || inFrame);
  assign showSum = (sumLeft != '0) && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      inFrame <= 1'b0;
      sumLeft <= '0;
    end else if (take && tap.e) begin
      inFrame <= 1'b0;
      sumLeft <= CW'(NCH);
    end else if (take && tap.s) begin
      inFrame <= 1'b1;
      sumLeft <= '0;
    end else if (showSum) begin
      sumLeft <= sumLeft - 1'b1;
    end
  end

  assign strb.dataStep   = take;
  assign strb.frameFirst = tap.s;
  assign strb.captureSum = take && tap.e;
  assign strb.shiftSum   = showSum;

  assign outValid = take || showSum;
  assign outStart = take && tap.s;
  assign outEnd   = showSum && (sumLeft == CW'(1));

  // R4: closing a frame is followed by an output sample next cycle
  a_r4_sum_follows: assert property (@(posedge clk) disable iff (rst)
    strb.captureSum |=> outValid);

  // R4: only one end per checksum
  a_r4_single_end: assert property (@(posedge clk) disable iff (rst)
    outEnd |=> !outEnd);

  // R7: a start that is not also an end clears pending emission
  a_r7_start_aborts: assert property (@(posedge clk) disable iff (rst)
    (outStart && !strb.captureSum) |=> (sumLeft == '0));

  // R3: a frame start is a valid sample and never the closing chunk
  a_r3_start_shape: assert property (@(posedge clk) disable iff (rst)
    outStart |-> (outValid && !outEnd));

endmodule

// File: rtl/crc_append_dp.sv
module crc_append_dp
  import crc_append_pkg::*;
#(
  parameter int DATA_W  = 2,
  parameter int CRC_LEN = 16,
  parameter int LAT     = 9,
  parameter logic [23:0] POLY_ALL = 24'h001021
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  crcStrobe_t        strb,
  output logic [DATA_W-1:0] outData
);

  localparam logic [CRC_LEN-1:0] POLY = POLY_ALL[CRC_LEN-1:0];

  // Data delay line, matched to the control delay line.
  for (genvar i = 0; i < LAT; i++) begin : g_stage
    logic [DATA_W-1:0] q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk) q <= inData;
    end else begin : g_tail
      always_ff @(posedge clk) q <= g_stage[i-1].q;
    end
  end

  logic [DATA_W-1:0]  tapData;
  logic [CRC_LEN-1:0] crcReg;
  logic [CRC_LEN-1:0] crcNext;
  logic [CRC_LEN-1:0] sumReg;

  assign tapData = g_stage[LAT-1].q;

  // Parallel update: DATA_W serial steps unrolled, top bit first.
  always_comb begin
    logic fb;
    crcNext = strb.frameFirst ? '0 : crcReg;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb      = crcNext[CRC_LEN-1] ^ tapData[b];
      crcNext = {crcNext[CRC_LEN-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crcReg <= '0;
    end else if (strb.dataStep) begin
      crcReg <= crcNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumReg <= '0;
    end else if (strb.captureSum) begin
      sumReg <= crcNext;
    end else if (strb.shiftSum) begin
      sumReg <= sumReg << DATA_W;
    end
  end

  assign outData = strb.shiftSum ? sumReg[CRC_LEN-1 -: DATA_W] : tapData;

  // R5: without an accepted sample the checksum state holds
  a_r5_crc_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.dataStep |=> $stable(crcReg));

endmodule

// File: rtl/crc_append_enc.sv
module crc_append_enc
  import crc_append_pkg::*;
#(
  parameter int DATA_W   = 2,
  parameter int CRC_KIND = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inEnd,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outStart,
  output logic              outEnd
);

  localparam int          CRC_LEN  = crcLenOf(CRC_KIND);
  localparam logic [23:0] POLY_ALL = crcPolyOf(CRC_KIND);
  localparam int          LAT      = (CRC_LEN + 3) / DATA_W;
  localparam int          NCH      = CRC_LEN / DATA_W;

  crcStrobe_t strb;

  crc_append_ctrl #(.LAT(LAT), .NCH(NCH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inStart  (inStart),
    .inEnd    (inEnd),
    .strb     (strb),
    .outValid (outValid),
    .outStart (outStart),
    .outEnd   (outEnd)
  );

  crc_append_dp #(
    .DATA_W   (DATA_W),
    .CRC_LEN  (CRC_LEN),
    .LAT      (LAT),
    .POLY_ALL (POLY_ALL)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .inData  (inData),
    .strb    (strb),
    .outData (outData)
  );

endmodule

// File: tb/crc_append_enc_bench.sv
module crc_append_enc_bench;

  localparam int W    = 2;
  localparam int L    = 16;
  localparam int LAT  = (L + 3) / W;
  localparam int NCH  = L / W;
  localparam int NCYC = 4000;
  localparam logic [L-1:0] POLY = 16'h1021;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst;
  logic [W-1:0] inData;
  logic         inValid, inStart, inEnd;
  logic [W-1:0] outData;
  logic         outValid, outStart, outEnd;

  crc_append_enc #(.DATA_W(W), .CRC_KIND(2)) u_crc_append_enc (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid),
    .inStart(inStart), .inEnd(inEnd), .outData(outData),
    .outValid(outValid), .outStart(outStart), .outEnd(outEnd)
  );

  // Input schedule
  logic         iV [NCYC];
  logic         iS [NCYC];
  logic         iE [NCYC];
  logic [W-1:0] iD [NCYC];
  string        tIn [NCYC];
  // Expected output timeline, indexed by observation cycle
  logic         eV [NCYC];
  logic         eS [NCYC];
  logic         eE [NCYC];
  logic         eSum [NCYC];
  logic [W-1:0] eD [NCYC];
  string        eTag [NCYC];

  int wp = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;
  int knownSumAt = -1;
  int winStart = -1;
  int winEnd = -1;
  string knownMsg = "123456789";

  function automatic logic [L-1:0] refStep(logic [L-1:0] c, logic [W-1:0] d);
    for (int b = W - 1; b >= 0; b--) begin
      logic fb;
      fb = c[L-1] ^ d[b];
      c  = {c[L-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  task automatic putCycle(logic v, logic s, logic e, logic [W-1:0] d, string tag);
    iV[wp] = v; iS[wp] = s; iE[wp] = e; iD[wp] = d; tIn[wp] = tag;
    wp++;
  endtask

  task automatic addIdle(int n, bit junk, string tag);
    for (int k = 0; k < n; k++) begin
      if (junk) putCycle(1'b0, 1'($urandom), 1'($urandom), W'($urandom), tag);
      else      putCycle(1'b0, 1'b0, 1'b0, '0, tag);
    end
  endtask

  task automatic addStray(int n, string tag);
    for (int k = 0; k < n; k++)
      putCycle(1'b1, 1'b0, 1'($urandom), W'($urandom), tag);
  endtask

  task automatic addFrame(int len, int holeProb, string tag, bit withEnd, bit known);
    for (int k = 0; k < len; k++) begin
      logic [W-1:0] d;
      while (int'($urandom_range(99)) < holeProb)
        putCycle(1'b0, 1'($urandom), 1'($urandom), W'($urandom), tag);
      if (known) d = W'(knownMsg[k/4] >> (6 - 2 * (k % 4)));
      else       d = W'($urandom);
      putCycle(1'b1, k == 0, withEnd && (k == len - 1), d, tag);
    end
  endtask

  task automatic buildExpected();
    bit inFrame = 0;
    logic [L-1:0] crc = '0;
    for (int c = 0; c < NCYC; c++) begin
      eV[c] = 0; eS[c] = 0; eE[c] = 0; eSum[c] = 0; eD[c] = '0; eTag[c] = "R5";
    end
    for (int c = 0; c < wp; c++) begin
      int o;
      o = c + LAT;
      eTag[o] = tIn[c];
      if (!iV[c]) continue;
      if (iS[c]) begin
        for (int j = o; j < NCYC; j++)
          if (eSum[j]) begin eV[j] = 0; eE[j] = 0; eSum[j] = 0; end
        crc = '0;
        inFrame = 1;
        if (tIn[c] == "R2" && winStart < 0) winStart = o;
      end
      if (!inFrame) continue;
      eV[o] = 1; eS[o] = iS[c]; eE[o] = 0; eD[o] = iD[c]; eSum[o] = 0;
      crc = refStep(crc, iD[c]);
      if (iE[c]) begin
        for (int k = 0; k < NCH; k++) begin
          int p;
          p = o + 1 + k;
          eV[p] = 1; eS[p] = 0; eE[p] = (k == NCH - 1); eSum[p] = 1;
          eD[p] = crc[L - 1 - W * k -: W];
          eTag[p] = (tIn[c] == "R3") ? "R4" : tIn[c];
        end
        if (tIn[c] == "R2") knownSumAt = o + 1;
        if (tIn[c] == "R8") winEnd = o + NCH;
        inFrame = 0;
      end
    end
  endtask

  task automatic check(bit ok, string tag, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, got no completion, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] gotSum;
    int winCount;
    void'($urandom(32'd4711));
    gotSum = '0;
    winCount = 0;

    // Schedule
    addIdle(3, 0, "R9");
    addFrame(36, 0, "R2", 1, 1);           // known vector, R1 and R2
    addIdle(NCH, 0, "R8");                 // minimum spacing, R8
    addFrame(20, 0, "R8", 1, 0);
    addIdle(12, 0, "R5");
    addFrame(25, 30, "R5", 1, 0);          // holes with junk flags, R5
    addIdle(10, 1, "R5");
    addStray(5, "R6");                     // out-of-frame samples, R6
    addIdle(2, 0, "R6");
    addFrame(10, 0, "R6", 1, 0);
    addStray(3, "R6");
    addIdle(10, 0, "R6");
    addFrame(1, 0, "R10", 1, 0);           // one-sample frames, R10
    addIdle(NCH, 0, "R10");
    addFrame(1, 0, "R10", 1, 0);
    addIdle(10, 0, "R10");
    addFrame(12, 0, "R7", 1, 0);           // early start over checksum, R7
    addIdle(3, 0, "R7");
    addFrame(6, 0, "R7", 0, 0);            // frame without end, R7
    addFrame(9, 0, "R7", 1, 0);
    addIdle(12, 0, "R7");
    for (int f = 0; f < 40; f++) begin     // random traffic, R3 and R4
      addFrame(int'($urandom_range(1, 40)), 15, "R3", 1, 0);
      addIdle(NCH + int'($urandom_range(0, 6)), 0, "R3");
    end
    buildExpected();

    // Reset, R9
    rst = 1'b1; inValid = 0; inStart = 0; inEnd = 0; inData = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!outValid && !outStart && !outEnd, "R9",
            $sformatf("in reset: got v%0b s%0b e%0b, expected 000", outValid, outStart, outEnd));
    end
    rst = 1'b0;

    for (int c = 0; c < wp + LAT + NCH + 2; c++) begin
      @(negedge clk);
      if (c < NCYC) begin
        bit ok;
        ok = (outValid === eV[c]) && (outStart === eS[c]) && (outEnd === eE[c]);
        if (eV[c]) ok = ok && (outData === eD[c]);
        check(ok, eTag[c], $sformatf("cycle %0d: got v%0b s%0b e%0b d%0h, expected v%0b s%0b e%0b d%0h",
              c, outValid, outStart, outEnd, outData, eV[c], eS[c], eE[c], eD[c]));
        if (knownSumAt >= 0 && c >= knownSumAt && c < knownSumAt + NCH)
          gotSum = {gotSum[L-W-1:0], outData};
        if (c >= winStart && c <= winEnd && outValid) winCount++;
      end
      if (c < wp) begin
        inValid = iV[c]; inStart = iS[c]; inEnd = iE[c]; inData = iD[c];
      end else begin
        inValid = 0; inStart = 0; inEnd = 0; inData = '0;
      end
    end

    check(gotSum == 16'h31C3, "R1",
          $sformatf("known vector checksum: got %0h, expected 31c3", gotSum));
    check(winCount == winEnd - winStart + 1, "R8",
          $sformatf("continuous valid: got %0d cycles, expected %0d", winCount, winEnd - winStart + 1));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule